// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block works out where a processor goes next after a branch instruction. It handles one branch per cycle on a 64-bit datapath whose bit numbers run from the most significant end. It also holds the three special registers that branches read and write: the link register, the count register and the target register. For each valid request it reports the resolved next address and whether the branch was taken. It then updates the link register, the count register or both.

Five kinds of branch are supported: an unconditional jump with a 24-bit immediate, a conditional branch with a 14-bit displacement, and conditional branches whose target is the link, count or target register. A conditional branch is taken only when two tests both pass. The first is a count test on the count register after an optional decrement. The second is a test of one condition-register bit. Fields of the 5-bit options word switch each test on or off and set its sense. A simple load port presets the special registers while no branch is in flight.

Top module: `branch_resolver`

## Requirements
- R1: With kind 0 (jump), the branch is always taken. The 24-bit immediate, with two zero bits appended, is sign-extended to 64 bits. It is the next address when aaFlag is 1 and is added to curAddr when aaFlag is 0.
- R2: With kind 1 (displacement), the 14-bit immediate is extended the same way. It is used as an absolute address when aaFlag is 1 and as an offset from curAddr when aaFlag is 0.
- R3: When lkFlag is 1 on a valid request of any kind, linkReg becomes curAddr + 4, whether or not the branch is taken.
- R4: Kinds 1, 2 (to link) and 4 (to target) decrement countReg by one when boField[2] is 0 and leave it unchanged when boField[2] is 1. Kinds 0 and 3 (to count) never change countReg.
- R5: The count test passes when boField[2] is 1. Otherwise it passes when (count after decrement is nonzero) XOR boField[1] is 1.
- R6: When wideMode is 1, the zero test looks at all 64 count bits. When wideMode is 0, it looks only at the low 32 bits, countReg[31:0].
- R7: The condition test passes when boField[4] is 1. Otherwise it passes when condition bit biField equals boField[3]. Condition bit n is condReg[31-n], so bit 0 is the most significant bit.
- R8: Kinds 1, 2 and 4 are taken only when both tests pass. Kind 3 is taken when the condition test alone passes.
- R9: Kinds 2, 3 and 4 target the link, count or target register respectively, with bits [1:0] forced to zero.
- R10: A branch that is not taken gives nextAddr = curAddr + 4.
- R11: Kind 2 with lkFlag 1 branches to the link value held before this instruction, not to the newly written curAddr + 4.
- R12: outValid, nextAddr and taken are registered. They appear one clock edge after the request, together with the register updates. outValid is 0 in every cycle that follows no request.
- R13: After reset, all three special registers are zero. When inValid is 0 and loadEn is 1, loadData is written to the register chosen by loadSel: 0 selects link, 1 selects count and 2 selects target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A branch request is present this cycle |
| kind | input | 3 | Branch kind: 0 jump, 1 displacement, 2 to link, 3 to count, 4 to target |
| aaFlag | input | 1 | Immediate is an absolute address |
| lkFlag | input | 1 | Write curAddr + 4 to the link register |
| boField | input | 5 | Options word; bit 4 is the most significant bit |
| biField | input | 5 | Condition bit index, counted from the most significant bit |
| immLong | input | 24 | Jump immediate |
| immShort | input | 14 | Displacement immediate |
| curAddr | input | 64 | Address of the branch instruction |
| condReg | input | 32 | Condition register |
| wideMode | input | 1 | Use a 64-bit count zero test |
| loadEn | input | 1 | Preset a special register; honoured only while inValid is 0 |
| loadSel | input | 2 | Register to preset |
| loadData | input | 64 | Preset value |
| outValid | output | 1 | Result is valid |
| nextAddr | output | 64 | Resolved next instruction address |
| taken | output | 1 | Branch was taken |
| linkReg | output | 64 | Link register |
| countReg | output | 64 | Count register |
| targetReg | output | 64 | Target register |

## Verification
A request applied before a rising edge produces its result at that edge. outValid, nextAddr and taken are registered, and the register updates appear at the same edge. The bench drives each request on a falling edge and pushes the predicted result and predicted register contents into a queue. A monitor wakes 1 ns after every rising edge and pops the queue whenever outValid is high, so every comparison falls exactly one edge after its request. A result that arrives with nothing expected, or a queue that is not empty once the bench goes idle, counts as a timing failure.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;

  typedef enum logic [2:0] {
    KIND_JUMP   = 3'd0,
    KIND_DISP   = 3'd1,
    KIND_LINK   = 3'd2,
    KIND_COUNT  = 3'd3,
    KIND_TARGET = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    SRC_IMM    = 2'd0,
    SRC_LINK   = 2'd1,
    SRC_COUNT  = 2'd2,
    SRC_TARGET = 2'd3
  } src_e;

  localparam int IDX_LINK   = 0;
  localparam int IDX_COUNT  = 1;
  localparam int IDX_TARGET = 2;
  localparam int NUM_SPR    = 3;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic fire;       // legal request this cycle
    logic decCount;   // decrement count register
    logic writeLink;  // write curAddr + 4 to link
    logic takeIt;     // branch resolved as taken
    logic absolute;   // immediate is absolute
    logic useLong;    // 24-bit immediate (else 14-bit)
    src_e src;        // target source
  } ctrl_t;

endpackage

// File: rtl/branch_resolver_ctrl.sv
module branch_resolver_ctrl
  import branch_resolver_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        kind,
  input  logic              aaFlag,
  input  logic              lkFlag,
  input  logic [4:0]        boField,
  input  logic [4:0]        biField,
  input  logic [CR_W-1:0]   condReg,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] countReg,
  output ctrl_t             ctl
);
  localparam int HALF_W = ADDR_W / 2;

  kind_e             kindE;
  logic              legal;
  logic              usesCtr;
  logic [ADDR_W-1:0] ctrAfter;
  logic              ctrNonZero;
  logic              ctrOk;
  logic [CR_W-1:0]   crShifted;
  logic              condOk;

  always_comb begin
    kindE   = kind_e'(kind);
    legal   = (kind <= 3'd4);
    usesCtr = (kindE == KIND_DISP) || (kindE == KIND_LINK) || (kindE == KIND_TARGET);

    ctl.fire      = inValid && legal;
    ctl.decCount  = ctl.fire && usesCtr && !boField[2];
    ctl.writeLink = ctl.fire && lkFlag;
    ctl.absolute  = aaFlag;
    ctl.useLong   = (kindE == KIND_JUMP);

    // Zero test on the count value seen after the optional decrement
    ctrAfter   = ctl.decCount ? countReg - ADDR_W'(1) : countReg;
    ctrNonZero = wideMode ? (|ctrAfter) : (|ctrAfter[HALF_W-1:0]);
    ctrOk      = boField[2] || (ctrNonZero ^ boField[1]);

    // Condition bit 0 is the most significant bit of condReg
    crShifted = condReg << biField;
    condOk    = boField[4] || (crShifted[CR_W-1] == boField[3]);

    unique case (kindE)
      KIND_JUMP:   begin ctl.takeIt = 1'b1;            ctl.src = SRC_IMM;    end
      KIND_DISP:   begin ctl.takeIt = ctrOk && condOk; ctl.src = SRC_IMM;    end
      KIND_LINK:   begin ctl.takeIt = ctrOk && condOk; ctl.src = SRC_LINK;   end
      KIND_COUNT:  begin ctl.takeIt = condOk;          ctl.src = SRC_COUNT;  end
      KIND_TARGET: begin ctl.takeIt = ctrOk && condOk; ctl.src = SRC_TARGET; end
      default:     begin ctl.takeIt = 1'b0;            ctl.src = SRC_IMM;    end
    endcase
  end

  // R1: a jump request always resolves as taken
  a_r1_jump_taken: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind == 3'd0) |-> ctl.takeIt);

  // R4: the to-count form never asks for a decrement
  a_r4_count_form_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind == 3'd3) |-> !ctl.decCount);

endmodule

// File: rtl/branch_resolver_dp.sv
module branch_resolver_dp
  import branch_resolver_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LI_W   = 24,
  parameter int BD_W   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [LI_W-1:0]   immLong,
  input  logic [BD_W-1:0]   immShort,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              loadEn,
  input  logic [1:0]        loadSel,
  input  logic [ADDR_W-1:0] loadData,
  output logic              outValid,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              taken,
  output logic [ADDR_W-1:0] linkReg,
  output logic [ADDR_W-1:0] countReg,
  output logic [ADDR_W-1:0] targetReg
);
  localparam int LI_PAD = ADDR_W - LI_W - 2;
  localparam int BD_PAD = ADDR_W - BD_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] specReg [NUM_SPR];
  logic [ADDR_W-1:0] brVal   [NUM_SPR];
  logic [NUM_SPR-1:0] brWe;

  logic [ADDR_W-1:0] longExt, shortExt, offset, immTarget, seqAddr, chosen;

  always_comb begin
    longExt   = {{LI_PAD{immLong[LI_W-1]}}, immLong, 2'b00};
    shortExt  = {{BD_PAD{immShort[BD_W-1]}}, immShort, 2'b00};
    offset    = ctl.useLong ? longExt : shortExt;
    immTarget = ctl.absolute ? offset : curAddr + offset;
    seqAddr   = curAddr + STEP;

    // Indirect sources read the registers before this cycle's updates
    unique case (ctl.src)
      SRC_LINK:   chosen = {specReg[IDX_LINK][ADDR_W-1:2], 2'b00};
      SRC_COUNT:  chosen = {specReg[IDX_COUNT][ADDR_W-1:2], 2'b00};
      SRC_TARGET: chosen = {specReg[IDX_TARGET][ADDR_W-1:2], 2'b00};
      default:    chosen = immTarget;
    endcase

    brWe               = '0;
    brWe[IDX_LINK]     = ctl.writeLink;
    brWe[IDX_COUNT]    = ctl.decCount;
    brVal[IDX_LINK]    = seqAddr;
    brVal[IDX_COUNT]   = specReg[IDX_COUNT] - ADDR_W'(1);
    brVal[IDX_TARGET]  = specReg[IDX_TARGET];
  end

  for (genvar g = 0; g < NUM_SPR; g++) begin : g_spr
    always_ff @(posedge clk) begin
      if (!rstN)
        specReg[g] <= '0;
      else if (brWe[g])
        specReg[g] <= brVal[g];
      else if (loadEn && !ctl.fire && loadSel == 2'(g))
        specReg[g] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      nextAddr <= '0;
      taken    <= 1'b0;
    end else begin
      outValid <= ctl.fire;
      if (ctl.fire) begin
        nextAddr <= ctl.takeIt ? chosen : seqAddr;
        taken    <= ctl.takeIt;
      end
    end
  end

  assign linkReg   = specReg[IDX_LINK];
  assign countReg  = specReg[IDX_COUNT];
  assign targetReg = specReg[IDX_TARGET];

  // R10: a branch that is not taken falls through to the next instruction
  a_r10_fall_through: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && outValid && !taken) |-> nextAddr == $past(curAddr) + STEP);

  // R3: the link register holds the return address after a linking request
  a_r3_link_written: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctl.writeLink)) |-> linkReg == $past(curAddr) + STEP);

  // R4: without a decrement strobe on a request the count register holds
  a_r4_count_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctl.fire) && !$past(ctl.decCount)) |-> $stable(countReg));

  // R9: register-sourced targets are word aligned
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && outValid && taken && $past(ctl.src) != SRC_IMM) |-> nextAddr[1:0] == 2'b00);

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_resolver_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 32,
  parameter int LI_W   = 24,
  parameter int BD_W   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        kind,
  input  logic              aaFlag,
  input  logic              lkFlag,
  input  logic [4:0]        boField,
  input  logic [4:0]        biField,
  input  logic [LI_W-1:0]   immLong,
  input  logic [BD_W-1:0]   immShort,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [CR_W-1:0]   condReg,
  input  logic              wideMode,
  input  logic              loadEn,
  input  logic [1:0]        loadSel,
  input  logic [ADDR_W-1:0] loadData,
  output logic              outValid,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              taken,
  output logic [ADDR_W-1:0] linkReg,
  output logic [ADDR_W-1:0] countReg,
  output logic [ADDR_W-1:0] targetReg
);
  ctrl_t ctl;

  branch_resolver_ctrl #(.ADDR_W(ADDR_W), .CR_W(CR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .kind(kind),
    .aaFlag(aaFlag), .lkFlag(lkFlag), .boField(boField), .biField(biField),
    .condReg(condReg), .wideMode(wideMode), .countReg(countReg), .ctl(ctl)
  );

  branch_resolver_dp #(.ADDR_W(ADDR_W), .LI_W(LI_W), .BD_W(BD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .immLong(immLong), .immShort(immShort),
    .curAddr(curAddr), .loadEn(loadEn), .loadSel(loadSel), .loadData(loadData),
    .outValid(outValid), .nextAddr(nextAddr), .taken(taken),
    .linkReg(linkReg), .countReg(countReg), .targetReg(targetReg)
  );

  // R12: a result follows exactly one edge after each legal request
  a_r12_result_timing: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid && kind <= 3'd4));

endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  kind = '0;
  logic        aaFlag = 1'b0, lkFlag = 1'b0;
  logic [4:0]  boField = '0, biField = '0;
  logic [23:0] immLong = '0;
  logic [13:0] immShort = '0;
  logic [63:0] curAddr = '0;
  logic [31:0] condReg = '0;
  logic        wideMode = 1'b1;
  logic        loadEn = 1'b0;
  logic [1:0]  loadSel = '0;
  logic [63:0] loadData = '0;
  logic        outValid, taken;
  logic [63:0] nextAddr, linkReg, countReg, targetReg;

  branch_resolver uut (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [63:0] nxt;
    logic        tk;
    logic [63:0] lnk, cnt, tgt;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [63:0] mLink = '0, mCount = '0, mTarget = '0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preset(logic [1:0] sel, logic [63:0] val);
    @(negedge clk);
    inValid = 1'b0; loadEn = 1'b1; loadSel = sel; loadData = val;
    case (sel)
      2'd0: mLink = val;
      2'd1: mCount = val;
      default: mTarget = val;
    endcase
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Driver: apply one request and predict its result from the requirements
  task automatic branch(logic [2:0] k, logic aa, logic lk, logic [4:0] bo, logic [4:0] bi,
                        logic [23:0] li, logic [13:0] bd, logic [63:0] cur,
                        logic [31:0] cr, logic wide, string tag);
    exp_t e;
    logic [63:0] ctrNew, imm, tgt;
    logic ctrOk, condOk, tk, nz, dec;
    @(negedge clk);
    inValid = 1'b1; kind = k; aaFlag = aa; lkFlag = lk; boField = bo; biField = bi;
    immLong = li; immShort = bd; curAddr = cur; condReg = cr; wideMode = wide;
    dec    = (k == 3'd1 || k == 3'd2 || k == 3'd4) && (bo[2] == 1'b0);
    ctrNew = dec ? mCount - 64'd1 : mCount;
    nz     = wide ? (ctrNew != 64'd0) : (ctrNew[31:0] != 32'd0);
    ctrOk  = bo[2] | (nz ^ bo[1]);
    condOk = bo[4] | (cr[31 - bi] == bo[3]);
    imm    = (k == 3'd0) ? 64'($signed({li, 2'b00})) : 64'($signed({bd, 2'b00}));
    case (k)
      3'd0: begin tk = 1'b1;           tgt = aa ? imm : cur + imm; end
      3'd1: begin tk = ctrOk & condOk; tgt = aa ? imm : cur + imm; end
      3'd2: begin tk = ctrOk & condOk; tgt = mLink & ~64'd3; end
      3'd3: begin tk = condOk;         tgt = mCount & ~64'd3; end
      default: begin tk = ctrOk & condOk; tgt = mTarget & ~64'd3; end
    endcase
    mCount = ctrNew;
    if (lk) mLink = cur + 64'd4;
    e.nxt = tk ? tgt : cur + 64'd4;
    e.tk = tk; e.lnk = mLink; e.cnt = mCount; e.tgt = mTarget; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: results are due one edge after the request
  always begin
    @(posedge clk);
    #1;
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        chk("R12 unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " nextAddr"}, nextAddr, e.nxt);
        chk({e.tag, " taken"}, 64'(taken), 64'(e.tk));
        chk("R3 linkReg", linkReg, e.lnk);
        chk("R4 countReg", countReg, e.cnt);
        chk("R13 targetReg", targetReg, e.tgt);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13 reset link", linkReg, 64'd0);
    chk("R13 reset count", countReg, 64'd0);
    chk("R13 reset target", targetReg, 64'd0);
    chk("R12 reset outValid", 64'(outValid), 64'd0);
    rstN = 1'b1;

    preset(2'd0, 64'h2003);
    preset(2'd1, 64'd3);
    preset(2'd2, 64'hABCF);
    @(negedge clk);
    chk("R13 load link", linkReg, 64'h2003);
    chk("R13 load count", countReg, 64'd3);
    chk("R13 load target", targetReg, 64'hABCF);

    // R1 jump, relative and absolute
    branch(3'd0, 0, 0, 5'b00000, 0, 24'h000010, 0, 64'h1000, 0, 1, "R1 jump rel");
    branch(3'd0, 1, 0, 5'b00000, 0, 24'hFFFFFF, 0, 64'h1000, 0, 1, "R1 jump abs neg");
    branch(3'd0, 0, 1, 5'b00000, 0, 24'hFFFFFC, 0, 64'h3000, 0, 1, "R3 jump link");
    // R2 displacement
    branch(3'd1, 0, 0, 5'b10100, 0, 0, 14'h3FFE, 64'h4000, 0, 1, "R2 disp rel neg");
    branch(3'd1, 1, 0, 5'b10100, 0, 0, 14'h0100, 64'h4000, 0, 1, "R2 disp abs");
    // R5 count test with decrement
    branch(3'd1, 0, 0, 5'b10000, 0, 0, 14'h0010, 64'h5000, 0, 1, "R5 nz taken");
    branch(3'd1, 0, 0, 5'b10010, 0, 0, 14'h0010, 64'h5000, 0, 1, "R10 zero test fails");
    branch(3'd1, 0, 0, 5'b10010, 0, 0, 14'h0010, 64'h5000, 0, 1, "R5 zero taken");
    idle();
    // R6 zero-test width
    preset(2'd1, 64'h1_0000_0001);
    branch(3'd1, 0, 0, 5'b10000, 0, 0, 14'h0020, 64'h6000, 0, 1, "R6 wide nonzero");
    idle();
    preset(2'd1, 64'h1_0000_0001);
    branch(3'd1, 0, 0, 5'b10000, 0, 0, 14'h0020, 64'h6000, 0, 0, "R6 narrow zero");
    // R7 condition bit test
    branch(3'd1, 0, 0, 5'b01100, 5'd3, 0, 14'h0008, 64'h7000, 32'h1000_0000, 1, "R7 bit set match");
    branch(3'd1, 0, 0, 5'b00100, 5'd3, 0, 14'h0008, 64'h7000, 32'h1000_0000, 1, "R7 bit set mismatch");
    branch(3'd1, 0, 0, 5'b01100, 5'd31, 0, 14'h0008, 64'h7000, 32'h0000_0001, 1, "R7 lowest bit");
    idle();
    // R8 both tests combined
    preset(2'd1, 64'd5);
    branch(3'd1, 0, 0, 5'b00000, 5'd0, 0, 14'h0004, 64'h8000, 32'h0, 1, "R8 both pass");
    branch(3'd1, 0, 0, 5'b00000, 5'd0, 0, 14'h0004, 64'h8000, 32'h8000_0000, 1, "R8 cond fails");
    idle();
    // R11 to-link with link update
    preset(2'd0, 64'h2003);
    branch(3'd2, 0, 1, 5'b10100, 0, 0, 0, 64'h9000, 0, 1, "R11 old link");
    idle();
    // R4 and R9: to-count never decrements
    preset(2'd1, 64'h5557);
    branch(3'd3, 0, 0, 5'b10000, 0, 0, 0, 64'hA000, 0, 1, "R4 count form");
    branch(3'd3, 0, 0, 5'b00000, 5'd0, 0, 0, 64'hA000, 32'h8000_0000, 1, "R8 count form cond");
    // R9 to-target; R3 link written when not taken
    branch(3'd4, 0, 0, 5'b10100, 0, 0, 0, 64'hB000, 0, 1, "R9 target");
    branch(3'd4, 0, 1, 5'b01100, 5'd0, 0, 0, 64'hC000, 32'h0, 1, "R3 not taken link");
    idle();
    repeat (3) @(negedge clk);
    chk("R12 queue drained", 64'(q.size()), 64'd0);
    chk("R12 idle outValid", 64'(outValid), 64'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule